// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is the host side of a three-wire serial EEPROM link. A single strobe starts a read: the block raises chip select, shifts out a read command made of a three-bit opcode and a word address as one MSB-first field, and then clocks in a 16-bit word. When the word is complete, chip select drops and the block pulses `done` for one cycle with the word on `rdWord`.

Two address widths are supported, 8 bits (wide) and 6 bits (narrow). A sizing read fetches word 255 (or word 63 in narrow mode). One bit of the result then sets the width used by every later read. A divider input sets how many clocks each half of a serial bit lasts. A typical use is to size the part once after reset and then fetch a 48-bit station address from words 0 to 2. The low byte of each word holds the earlier address byte.

Top module: `serEepromReader`

## Requirements
- R1: After reset and between transactions, `csOut`, `sclkOut`, `sdOut`, `busy` and `done` are low, `addrWide` is 1 (8-bit addressing) and `rdWord` is 0 until the first read completes.
- R2: A transaction opens with one select phase: `csOut` high, `sclkOut` low. `csOut` stays high through the high phase of the 16th data bit and falls in the cycle in which `done` is high.
- R3: The command field is opcode 110 followed by the address, MSB first. In wide mode it is 11 bits carrying `wordAddr[7:0]`. In narrow mode it is 9 bits carrying `wordAddr[5:0]`.
- R4: Every serial bit has a low phase then a high phase, each lasting `divLimit`+1 clocks. `sdOut` is set at the start of the low phase and does not change at the rising edge of `sclkOut`. `sclkOut` is high only while `csOut` is high.
- R5: Exactly 16 data bits are captured MSB first. Each bit is sampled from `sdIn` on the last clock of its high phase. `sdOut` is low during the data bits.
- R6: `rdWord` changes only in the cycle in which `done` is high. `done` is a one-cycle pulse. `busy` is high from the cycle after the accepted start through the `done` cycle.
- R7: A `startReq` while `busy` is high has no effect on the running transaction or its outputs.
- R8: A start with `sizeReq` high reads address 255, truncated to the current width. In the `done` cycle, `addrWide` takes bit 15 of the word read (1 = 8-bit, 0 = 6-bit).
- R9: `divLimit`, `wordAddr` and `sizeReq` are captured when a start is accepted. Later changes do not alter the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a read when idle |
| sizeReq | input | 1 | Make this read the sizing read |
| wordAddr | input | 8 | Word address to read |
| divLimit | input | DIV_W | Clocks per serial phase minus one |
| sdIn | input | 1 | Serial data from the EEPROM |
| csOut | output | 1 | Chip select |
| sclkOut | output | 1 | Serial clock |
| sdOut | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdWord | output | 16 | Last word read |
| addrWide | output | 1 | 1 = 8-bit addressing, 0 = 6-bit |

## Verification
A behavioural device model in the bench decodes the command from the pins and answers with an address-dependent word. Every cycle the outputs are compared with an integer phase model. Reads at divider values 0, 1 and 3 separate the phase-length arithmetic from the bit ordering. Sizing reads steered to each outcome show that the command length follows the chosen width and that narrow mode truncates the address. A start pulse and a divider change injected mid-read show whether the parameters are captured at the start or read live.

// File: rtl/serEeprom_pkg.sv
package serEeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD,
    ST_DATA,
    ST_FIN
  } ctrlState_t;

  typedef struct packed {
    logic loadCmd;
    logic shiftCmd;
    logic sampleIn;
    logic lastSample;
    logic captureSize;
    logic driveCmd;
  } ctrlStrobe_t;

  localparam logic [2:0] READ_OPCODE = 3'b110;

endpackage

// File: rtl/serEepromCtrl.sv
module serEepromCtrl
  import serEeprom_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int WIDE_ADDR   = 8,
  parameter int NARROW_ADDR = 6,
  parameter int WORD_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             sizeReq,
  input  logic [DIV_W-1:0] divLimit,
  input  logic             addrWide,
  output ctrlStrobe_t      strb,
  output logic             csOut,
  output logic             sclkOut,
  output logic             busy,
  output logic             done
);

  localparam int CMD_WIDE   = WIDE_ADDR + 3;
  localparam int CMD_NARROW = NARROW_ADDR + 3;
  localparam int CNT_MAX    = (CMD_WIDE > WORD_W) ? CMD_WIDE : WORD_W;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  ctrlState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimQ;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] cmdLenQ;
  logic             hiPh;
  logic             sizeQ;
  logic             phaseEnd;
  logic [CNT_W-1:0] cmdLenNew;

  assign phaseEnd  = (divCnt == divLimQ);
  assign cmdLenNew = addrWide ? CNT_W'(CMD_WIDE) : CNT_W'(CMD_NARROW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      divLimQ <= '0;
      bitCnt  <= '0;
      cmdLenQ <= '0;
      hiPh    <= 1'b0;
      sizeQ   <= 1'b0;
    end else begin
      if (state == ST_IDLE || phaseEnd) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_SEL;
            divLimQ <= divLimit;
            cmdLenQ <= cmdLenNew;
            sizeQ   <= sizeReq;
            hiPh    <= 1'b0;
            bitCnt  <= '0;
          end
        end
        ST_SEL: begin
          if (phaseEnd) begin
            state  <= ST_CMD;
            hiPh   <= 1'b0;
            bitCnt <= '0;
          end
        end
        ST_CMD: begin
          if (phaseEnd) begin
            if (!hiPh) begin
              hiPh <= 1'b1;
            end else begin
              hiPh <= 1'b0;
              if (bitCnt == cmdLenQ - 1'b1) begin
                state  <= ST_DATA;
                bitCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        ST_DATA: begin
          if (phaseEnd) begin
            if (!hiPh) begin
              hiPh <= 1'b1;
            end else begin
              hiPh <= 1'b0;
              if (bitCnt == CNT_W'(WORD_W - 1)) state <= ST_FIN;
              else bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb             = '0;
    strb.loadCmd     = (state == ST_IDLE) && startReq;
    strb.shiftCmd    = (state == ST_CMD) && phaseEnd && hiPh;
    strb.sampleIn    = (state == ST_DATA) && phaseEnd && hiPh;
    strb.lastSample  = strb.sampleIn && (bitCnt == CNT_W'(WORD_W - 1));
    strb.captureSize = strb.lastSample && sizeQ;
    strb.driveCmd    = (state == ST_CMD);
  end

  assign csOut   = (state == ST_SEL) || (state == ST_CMD) || (state == ST_DATA);
  assign sclkOut = ((state == ST_CMD) || (state == ST_DATA)) && hiPh;
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);

endmodule

// File: rtl/serEepromData.sv
module serEepromData
  import serEeprom_pkg::*;
#(
  parameter int WIDE_ADDR   = 8,
  parameter int NARROW_ADDR = 6,
  parameter int WORD_W      = 16,
  parameter int SIZE_BIT    = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic                 sizeReq,
  input  logic [WIDE_ADDR-1:0] wordAddr,
  input  logic                 sdIn,
  output logic                 sdOut,
  output logic [WORD_W-1:0]    rdWord,
  output logic                 addrWide
);

  localparam int CMD_W = WIDE_ADDR + 3;
  localparam int PAD_W = WIDE_ADDR - NARROW_ADDR;

  logic [CMD_W-1:0]     cmdShift;
  logic [CMD_W-1:0]     cmdWideVal;
  logic [CMD_W-1:0]     cmdNarrowVal;
  logic [WIDE_ADDR-1:0] addrPick;
  logic [WORD_W-1:0]    inShift;
  logic [WORD_W-1:0]    nextWord;

  assign addrPick   = sizeReq ? '1 : wordAddr;
  assign cmdWideVal = {READ_OPCODE, addrPick};

  generate
    if (PAD_W > 0) begin : gNarrowPad
      assign cmdNarrowVal = {READ_OPCODE, addrPick[NARROW_ADDR-1:0], {PAD_W{1'b0}}};
    end else begin : gNarrowSame
      assign cmdNarrowVal = {READ_OPCODE, addrPick};
    end
  endgenerate

  assign nextWord = {inShift[WORD_W-2:0], sdIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdShift <= '0;
      inShift  <= '0;
      rdWord   <= '0;
      addrWide <= 1'b1;
    end else begin
      if (strb.loadCmd) cmdShift <= addrWide ? cmdWideVal : cmdNarrowVal;
      else if (strb.shiftCmd) cmdShift <= {cmdShift[CMD_W-2:0], 1'b0};
      if (strb.sampleIn) inShift <= nextWord;
      if (strb.lastSample) rdWord <= nextWord;
      if (strb.captureSize) addrWide <= nextWord[SIZE_BIT];
    end
  end

  assign sdOut = strb.driveCmd & cmdShift[CMD_W-1];

endmodule

// File: rtl/serEepromReader.sv
module serEepromReader
  import serEeprom_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int WIDE_ADDR   = 8,
  parameter int NARROW_ADDR = 6,
  parameter int WORD_W      = 16,
  parameter int SIZE_BIT    = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 sizeReq,
  input  logic [WIDE_ADDR-1:0] wordAddr,
  input  logic [DIV_W-1:0]     divLimit,
  input  logic                 sdIn,
  output logic                 csOut,
  output logic                 sclkOut,
  output logic                 sdOut,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_W-1:0]    rdWord,
  output logic                 addrWide
);

  ctrlStrobe_t strb;

  serEepromCtrl #(
    .DIV_W(DIV_W), .WIDE_ADDR(WIDE_ADDR), .NARROW_ADDR(NARROW_ADDR), .WORD_W(WORD_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sizeReq(sizeReq),
    .divLimit(divLimit), .addrWide(addrWide), .strb(strb),
    .csOut(csOut), .sclkOut(sclkOut), .busy(busy), .done(done)
  );

  serEepromData #(
    .WIDE_ADDR(WIDE_ADDR), .NARROW_ADDR(NARROW_ADDR), .WORD_W(WORD_W), .SIZE_BIT(SIZE_BIT)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sizeReq(sizeReq), .wordAddr(wordAddr),
    .sdIn(sdIn), .sdOut(sdOut), .rdWord(rdWord), .addrWide(addrWide)
  );

endmodule

// File: rtl/serEepromReader_chk.sv
module serEepromReader_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              csOut,
  input logic              sclkOut,
  input logic              sdOut,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] rdWord
);

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!csOut && !sclkOut && !sdOut)); // R1

  AST_CS_FALLS_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csOut) |-> done); // R2

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> csOut); // R4

  AST_SDO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> $stable(sdOut)); // R4

  AST_WORD_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdWord) |-> done); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R6

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R7

endmodule

bind serEepromReader serEepromReader_chk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .csOut(csOut), .sclkOut(sclkOut), .sdOut(sdOut),
  .busy(busy), .done(done), .rdWord(rdWord)
);

// File: tb/serEepromReader_test.sv
module serEepromReader_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        sizeReq = 1'b0;
  logic [7:0]  wordAddr = 8'h00;
  logic [7:0]  divLimit = 8'h00;
  logic        sdIn = 1'b0;
  logic        csOut, sclkOut, sdOut, busy, done, addrWide;
  logic [15:0] rdWord;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  // model state
  bit          mActive = 0;
  int          k = 0, P = 1, L = 11, finK = 0;
  int          mCmd = 0;
  bit          mSize = 0;
  bit          mWide = 1;
  logic [15:0] mRd = 16'h0;
  int          mAddr = 0;
  logic [15:0] salt = 16'h0;

  // device model state
  int          rises = 0;
  int          rx = 0;
  bit          prevSclk = 0;
  logic [15:0] devWord = 16'h0;

  always #10 clk = ~clk;

  serEepromReader uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sizeReq(sizeReq),
    .wordAddr(wordAddr), .divLimit(divLimit), .sdIn(sdIn),
    .csOut(csOut), .sclkOut(sclkOut), .sdOut(sdOut), .busy(busy),
    .done(done), .rdWord(rdWord), .addrWide(addrWide)
  );

  function automatic logic [15:0] memWord(input int a);
    logic [31:0] prod;
    prod = a * 32'h9E37;
    return prod[15:0] ^ salt;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!finished) begin
      int q;
      bit ecs, esclk, esdo, ebusy, edone;
      // reference model update
      if (mActive) begin
        k++;
        if (k > finK) mActive = 0;
      end else if (rstN && startReq) begin
        mActive = 1;
        k = 1;
        P = int'(divLimit) + 1;
        L = mWide ? 11 : 9;
        mSize = sizeReq;
        mAddr = sizeReq ? 255 : int'(wordAddr);
        mAddr = mWide ? (mAddr & 255) : (mAddr & 63);
        mCmd = (6 << (L - 3)) | mAddr;
        finK = P * (1 + 2 * L + 32) + 1;
      end
      if (mActive && k == finK) begin
        mRd = memWord(mAddr);
        if (mSize) mWide = mRd[15];
      end
      q = mActive ? (k - 1) / P : 0;
      ecs   = mActive && k < finK;
      esclk = ecs && q >= 1 && (q % 2 == 0);
      esdo  = ecs && q >= 1 && q <= 2 * L && mCmd[L - 1 - (q - 1) / 2];
      ebusy = mActive;
      edone = mActive && k == finK;
      vectors++;
      cmp("R1/R2 csOut", csOut, ecs);
      cmp("R4/R5 sclkOut", sclkOut, esclk);
      cmp("R3/R5 sdOut", sdOut, esdo);
      cmp("R6/R7 busy", busy, ebusy);
      cmp("R6 done", done, edone);
      cmp("R5/R6 rdWord", rdWord, mRd);
      cmp("R8 addrWide", addrWide, mWide);
      // device model driven from the pins
      if (!csOut) begin
        rises = 0;
        rx = 0;
      end else if (sclkOut && !prevSclk) begin
        rises++;
        if (rises <= L) begin
          rx = (rx << 1) | int'(sdOut);
          if (rises == L) begin
            vectors++;
            cmp("R3 command field", rx, mCmd);
            devWord = memWord(rx & ((1 << (L - 3)) - 1));
          end
        end
      end
      if (csOut && rises > L && rises <= L + 16) sdIn = devWord[15 - (rises - L - 1)];
      else sdIn = 1'b0;
      prevSclk = sclkOut;
    end
  end

  task automatic runRead(input logic [7:0] addr, input bit sz, input logic [7:0] dv);
    @(negedge clk);
    wordAddr = addr;
    sizeReq = sz;
    divLimit = dv;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state checked each cycle by the model comparison
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // station address words, fastest divider (R3, R5)
    runRead(8'h00, 0, 8'd0);
    runRead(8'h01, 0, 8'd0);
    runRead(8'h02, 0, 8'd0);
    // R4: longer phases
    runRead(8'hA5, 0, 8'd3);
    // R7 and R9: start pulse and divider change in the middle of a read
    @(negedge clk);
    wordAddr = 8'h3C; sizeReq = 0; divLimit = 8'd1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (20) @(negedge clk);
    wordAddr = 8'hFF; sizeReq = 1; divLimit = 8'd4; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; sizeReq = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    // R8: sizing steered to narrow addressing
    salt = 16'h8000;
    runRead(8'h00, 1, 8'd0);
    // R3: narrow mode truncates the address
    runRead(8'hC7, 0, 8'd1);
    runRead(8'h3F, 0, 8'd2);
    // R8: sizing from narrow mode reads word 63 and returns to wide
    salt = 16'h0000;
    runRead(8'h12, 1, 8'd0);
    runRead(8'h80, 0, 8'd0);
    // R1: idle again
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule